// File: doc/BRIEF.md
# Constant-Off-Time Current Limit Regulator

This block is the digital timing core of a peak-current limiter for a full-bridge motor driver. Analog comparators outside the block report three conditions: load current above the regulation limit, load current above the short-circuit level, and a junction hot enough to need the reduced limit. The block turns these flags into a request to tri-state the bridge. It also selects which limit threshold the comparator uses and raises a short-circuit fault pulse.

A limit trip seen while the bridge is driven forces the bridge off for a fixed number of cycles. Normal drive then resumes. Every output transition starts a blanking window during which the limit flag is ignored, which gives the short-circuit comparator time to act. The end of an off period counts as such a transition. A short-circuit trip is checked in every cycle, blanking or not. It latches the bridge off until the drive command is withdrawn. The off time and the blanking time are parameters counted in clock cycles. A 1 MHz tick with 20 off cycles and 16 blanking cycles gives the nominal timing.

Top module: `clim_regulator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, force_off, short_fault and limit_low_sel are 0, and no blanking or off period is running.
- R2: With drive_on high, ovr_short low, no blanking, no off period and no latched fault, a high ovr_limit sampled at a clock edge makes force_off 1 after that edge.
- R3: edge_pulse sampled at edge k opens a blanking window. ovr_limit is ignored at edges k through k+BLANK_CYC and can trip at edge k+BLANK_CYC+1 at the earliest.
- R4: An off period holds force_off at 1 for exactly OFF_CYC cycles and then releases it. A limit trip is not restarted while it runs.
- R5: The edge at which an off period ends opens a new blanking window of BLANK_CYC cycles, as edge_pulse does.
- R6: With drive_on low, ovr_limit has no effect on force_off.
- R7: A high ovr_short sampled with drive_on high and no latched fault makes force_off 1 after that edge, inside a blanking window or not. It also makes short_fault 1 for exactly that one cycle.
- R8: After a short circuit, force_off stays 1 whatever ovr_limit and ovr_short do, and short_fault does not pulse again. The latch clears at the first edge that samples drive_on low, and force_off is 0 after that edge.
- R9: When ovr_short and ovr_limit are both high at the same edge, the short-circuit path alone responds and no off period starts.
- R10: limit_low_sel equals the value of hot_fold sampled at the previous clock edge (1 selects the reduced threshold).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one tick per counted cycle) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| drive_on | input | 1 | Bridge is commanded to drive the load |
| edge_pulse | input | 1 | One-cycle pulse on each output transition |
| ovr_limit | input | 1 | Comparator: load current above regulation limit |
| ovr_short | input | 1 | Comparator: load current above short-circuit level |
| hot_fold | input | 1 | Junction temperature in the foldback region |
| force_off | output | 1 | Request to tri-state all bridge switches |
| limit_low_sel | output | 1 | Select reduced current-limit threshold |
| short_fault | output | 1 | One-cycle short-circuit fault pulse |

## Verification
Two pairs of functions can fall in the same cycle. A short-circuit trip and a limit trip are provoked together outside blanking. The drive command is then withdrawn two cycles later, and force_off must drop at once; if an off period had also started, it would still be high. A short-circuit trip is also raised inside an active blanking window, where the limit flag is being ignored, and must latch the bridge off on the next edge. The end of an off period and the re-arming of blanking fall on one edge. This is judged by holding the limit flag high through the whole sequence and checking that the second trip lands exactly BLANK_CYC+1 edges after the release.

// File: rtl/clim_pkg.sv
package clim_pkg;

  // width of a down-counter that must hold the value n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  typedef struct packed {
    logic latched;
    logic pulse;
  } short_state_t;

endpackage

// File: rtl/clim_blank_timer.sv
module clim_blank_timer #(
  parameter int BLANK_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic busy
);
  localparam int W = clim_pkg::cnt_width(BLANK_CYC);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = arm || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (arm)               cnt_d = W'(BLANK_CYC);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R3: once armed the window stays open until the count is spent
  a_r3_window_open: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> busy);

endmodule

// File: rtl/clim_off_timer.sv
module clim_off_timer #(
  parameter int OFF_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int W = clim_pkg::cnt_width(OFF_CYC);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (start && (cnt_q == '0)) cnt_d = W'(OFF_CYC);
    else if (cnt_q != '0)       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
  assign done   = (cnt_q == W'(1));

  // R4: an off period is never cut short before its last cycle
  a_r4_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> active);

  // R4: a start never lands on a running period
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !start);

endmodule

// File: rtl/clim_short_latch.sv
module clim_short_latch (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  drive_on,
  input  logic                  short_hit,
  output clim_pkg::short_state_t st
);
  clim_pkg::short_state_t st_q, st_d;
  logic                   set_now;

  always_comb begin
    set_now    = drive_on && short_hit && !st_q.latched;
    st_d.pulse = set_now;
    if (!drive_on)    st_d.latched = 1'b0;
    else if (set_now) st_d.latched = 1'b1;
    else              st_d.latched = st_q.latched;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st = st_q;

  // R7: the fault pulse lasts a single cycle
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.pulse |=> !st_q.pulse);

  // R8: a held latch with drive kept on stays set
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.latched && drive_on) |=> st_q.latched);

endmodule

// File: rtl/clim_regulator.sv
module clim_regulator #(
  parameter int OFF_CYC   = 20,
  parameter int BLANK_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_on,
  input  logic edge_pulse,
  input  logic ovr_limit,
  input  logic ovr_short,
  input  logic hot_fold,
  output logic force_off,
  output logic limit_low_sel,
  output logic short_fault
);
  logic                   blank_busy, blanking, rearm;
  logic                   off_active, off_done, trip;
  logic                   low_sel_q;
  clim_pkg::short_state_t sc_st;

  // a transition and the end of an off period both re-arm blanking
  assign rearm    = edge_pulse || off_done;
  assign blanking = blank_busy || edge_pulse;

  assign trip = drive_on && ovr_limit && !ovr_short && !blanking
                && !off_active && !sc_st.latched;

  clim_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (rearm),
    .busy  (blank_busy)
  );

  clim_off_timer #(.OFF_CYC(OFF_CYC)) u_off (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (trip),
    .active (off_active),
    .done   (off_done)
  );

  clim_short_latch u_short (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_on  (drive_on),
    .short_hit (ovr_short),
    .st        (sc_st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_sel_q <= 1'b0;
    else        low_sel_q <= hot_fold;
  end

  assign force_off     = sc_st.latched || off_active;
  assign short_fault   = sc_st.pulse;
  assign limit_low_sel = low_sel_q;

  // R2: a qualified limit trip forces the bridge off on the next edge
  a_r2_trip_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_on && ovr_limit && !ovr_short && !blanking && !force_off) |=> force_off);

  // R3: inside blanking, the limit flag alone cannot turn the bridge off
  a_r3_blank_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (blanking && !ovr_short && !force_off) |=> !force_off);

  // R6: without drive, a limit flag alone changes nothing
  a_r6_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_on && !force_off) |=> !force_off);

  // R7: a short with drive on turns the bridge off on the next edge
  a_r7_short_off: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_on && ovr_short) |=> force_off);

  // R9: a fault pulse never comes with a freshly started off period
  a_r9_short_wins: assert property (@(posedge clk) disable iff (!rst_n)
    short_fault |-> !off_active || $past(off_active));

  // R10: threshold select follows the temperature flag one edge later
  a_r10_fold_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (limit_low_sel == $past(hot_fold)));

endmodule

// File: tb/sim_clim_regulator.sv
module sim_clim_regulator;
  localparam int PERIOD = 10;
  localparam int OFFC   = 20;
  localparam int BLNK   = 16;
  localparam int WDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drive_on = 1'b0, edge_pulse = 1'b0, ovr_limit = 1'b0;
  logic ovr_short = 1'b0, hot_fold = 1'b0;
  logic force_off, limit_low_sel, short_fault;

  int checks = 0;
  int errors = 0;
  bit done_all = 1'b0;

  typedef struct {
    logic  xo;
    logic  xl;
    logic  xf;
    string tag;
  } exp_t;
  exp_t q[$];

  always #(PERIOD/2) clk = ~clk;

  clim_regulator #(.OFF_CYC(OFFC), .BLANK_CYC(BLNK)) u0 (
    .clk(clk), .rst_n(rst_n), .drive_on(drive_on), .edge_pulse(edge_pulse),
    .ovr_limit(ovr_limit), .ovr_short(ovr_short), .hot_fold(hot_fold),
    .force_off(force_off), .limit_low_sel(limit_low_sel), .short_fault(short_fault)
  );

  task automatic chk(input logic act, input logic xp, input string what, input string tag);
    checks++;
    if (act !== xp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, xp, $time);
    end
  endtask

  // driver: applies one cycle of inputs and queues the outputs expected after the edge
  task automatic cyc(input logic d, e, l, s, h, input logic xo, xl, xf, input string tag);
    exp_t x;
    @(negedge clk);
    drive_on = d; edge_pulse = e; ovr_limit = l; ovr_short = s; hot_fold = h;
    x.xo = xo; x.xl = xl; x.xf = xf; x.tag = tag;
    q.push_back(x);
  endtask

  // monitor: compares each queued item with the outputs after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        chk(force_off, x.xo, "force_off", x.tag);
        chk(limit_low_sel, x.xl, "limit_low_sel", x.tag);
        chk(short_fault, x.xf, "short_fault", x.tag);
      end
    end
  end

  initial begin
    for (int i = 0; i < WDOG; i++) @(posedge clk);
    if (!done_all) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #(PERIOD/4);
    chk(force_off, 1'b0, "force_off in reset", "R1");
    chk(short_fault, 1'b0, "short_fault in reset", "R1");
    chk(limit_low_sel, 1'b0, "limit_low_sel in reset", "R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(0,0,0,0,0, 0,0,0, "R1 idle");

    // R10: threshold select
    cyc(0,0,0,0,1, 0,1,0, "R10 hot");
    cyc(0,0,0,0,1, 0,1,0, "R10 hot hold");
    cyc(0,0,0,0,0, 0,0,0, "R10 cool");

    // R6: limit flag without drive
    for (int i = 0; i < 5; i++) cyc(0,0,1,0,0, 0,0,0, "R6 no drive");

    // R2/R3/R4/R5: blanking, trip, off period, re-arm, second trip
    for (int c = 0; c <= 2*BLNK+2*OFFC+3; c++) begin
      logic xo;
      string t;
      xo = ((c >= BLNK+1) && (c <= BLNK+OFFC)) ||
           ((c >= 2*BLNK+OFFC+2) && (c <= 2*BLNK+2*OFFC+1));
      if (c <= BLNK) t = "R3 blanking";
      else if (c <= BLNK+OFFC) t = "R4 off period";
      else if (c < 2*BLNK+OFFC+2) t = "R5 rearm";
      else t = "R2 second trip";
      cyc(1, (c == 0), (c <= 2*BLNK+OFFC+2), 0, 0, xo, 0, 0, t);
    end
    for (int i = 0; i < BLNK+2; i++) cyc(0,0,0,0,0, 0,0,0, "R4 released");

    // R7/R8: short inside blanking, latch hold, clear on drive low
    cyc(1,1,0,0,0, 0,0,0, "R3 edge");
    cyc(1,0,1,0,0, 0,0,0, "R3 blank");
    cyc(1,0,1,0,0, 0,0,0, "R3 blank");
    cyc(1,0,0,1,0, 1,0,1, "R7 short in blanking");
    cyc(1,0,1,0,0, 1,0,0, "R7 pulse ends");
    cyc(1,0,1,0,0, 1,0,0, "R8 latched");
    cyc(1,0,1,1,0, 1,0,0, "R8 no repulse");
    cyc(1,0,0,1,0, 1,0,0, "R8 no repulse");
    cyc(1,0,0,0,0, 1,0,0, "R8 latched");
    cyc(0,0,1,0,0, 0,0,0, "R8 cleared");
    cyc(0,0,1,0,0, 0,0,0, "R6 after clear");
    for (int i = 0; i < BLNK+2; i++) cyc(0,0,0,0,0, 0,0,0, "R8 idle");

    // R9: short and limit on the same edge
    cyc(1,0,1,1,0, 1,0,1, "R9 both trip");
    cyc(1,0,1,0,0, 1,0,0, "R9 latched");
    cyc(1,0,1,0,0, 1,0,0, "R9 latched");
    cyc(0,0,1,0,0, 0,0,0, "R9 no off period");
    cyc(0,0,0,0,0, 0,0,0, "R9 idle");

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done_all = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule